// File: doc/BRIEF.md
# Audio FIFO DMA Request and Interrupt Logic

This block sits next to the transmit and receive sample FIFOs of an audio serial port. It watches the occupancy count of each FIFO and turns it into a DMA request line for each direction. Each direction can ask for transfers one word at a time or in bursts of four words. It also keeps four status flags and merges them into one interrupt line. Two of the flags are sticky: transmit underrun and receive overrun. The other two follow the FIFO levels: transmit level at or below its low mark, and receive level at or above its high mark.

Software controls each direction through four inputs: a DMA enable, a burst select, a debug hold-off and a flush. While the processor is in debug mode and the hold-off is set, that direction's requests are held low. A flush pulse removes the request for one cycle and clears that direction's sticky error flag. The FIFOs and the DMA controller are outside this block. All request and flag outputs are registered, so they follow their inputs by one clock. The interrupt line is a gate on the registered flags and follows its enable mask in the same cycle.

Top module: `audio_fifo_dreq`

## Requirements
- R1: While rst_n is low, tx_dreq, rx_dreq, all four flags and irq are 0.
- R2: With tx_burst=0, tx_dreq is 1 one cycle after a cycle in which tx_level < 8 (free space exists), tx_dma_en=1, there is no debug hold-off and tx_flush=0. A level of 8 or more gives 0.
- R3: With tx_burst=1 the same holds with the condition tx_level <= 4 (fewer than five words held) in place of free space.
- R4: With rx_burst=0, rx_dreq is 1 one cycle after a cycle in which rx_level >= 1, rx_dma_en=1, there is no debug hold-off and rx_flush=0.
- R5: With rx_burst=1 the same holds with the condition rx_level >= 4 (more than three words held).
- R6: A direction whose DMA enable is 0 has its request at 0 on the following cycle, whatever its level.
- R7: When dbg_active=1 and a direction's debug hold-off input is 1, that direction's request is 0 on the next cycle. A direction whose hold-off input is 0 is not affected.
- R8: A flush pulse forces that direction's request to 0 for the next cycle. It also clears that direction's sticky flag, unless an error event arrives in the same cycle.
- R9: flags[2] (transmit low mark) is 1 one cycle after a cycle in which tx_level <= tx_wmark, and 0 otherwise.
- R10: flags[3] (receive high mark) is 1 one cycle after a cycle in which rx_level >= rx_wmark, and 0 otherwise.
- R11: flags[0] (transmit underrun) and flags[1] (receive overrun) are set the cycle after their event pulse. They then hold until err_clr bit 0 or bit 1 (or the flush of that direction) clears them. An event in the same cycle as a clear wins.
- R12: irq equals the OR over the four flags of each flag ANDed with the irq_en bit of the same index. It is combinational from the registered flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_level | input | 4 | Transmit FIFO occupancy in words |
| rx_level | input | 4 | Receive FIFO occupancy in words |
| tx_wmark | input | 4 | Transmit low mark |
| rx_wmark | input | 4 | Receive high mark |
| tx_burst | input | 1 | 1 selects four-word transmit bursts |
| rx_burst | input | 1 | 1 selects four-word receive bursts |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_dbg_hold | input | 1 | Hold transmit requests off in debug mode |
| rx_dbg_hold | input | 1 | Hold receive requests off in debug mode |
| dbg_active | input | 1 | Processor is in debug mode |
| tx_underrun | input | 1 | Pulse: transmit FIFO read while empty |
| rx_overrun | input | 1 | Pulse: receive FIFO written while full |
| tx_flush | input | 1 | Pulse: transmit FIFO flushed |
| rx_flush | input | 1 | Pulse: receive FIFO flushed |
| err_clr | input | 2 | Software clear, bit 0 underrun, bit 1 overrun |
| irq_en | input | 4 | Interrupt enable per flag, same indices as flags |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| flags | output | 4 | 0 underrun, 1 overrun, 2 tx low mark, 3 rx high mark |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check these rules on every cycle:
- each request against its occupancy threshold, in both burst modes;
- the effect of the enables, the debug hold-off and flush;
- the two level flags against their marks;
- that the sticky flags are set by events and keep their value otherwise;
- the interrupt gating.

Some behaviour only the bench's scenarios can show. One case is a sticky flag that stays set across many idle cycles and then clears only on the software pulse. Another is an event that wins over a clear in the same cycle. A third is a request that comes back on the cycle after a flush. A fourth is a level above the FIFO depth that produces no transmit request.

// File: rtl/audio_fifo_dreq_pkg.sv
package audio_fifo_dreq_pkg;

  localparam int NUM_FLAGS = 4;

  // flag indices; the bench and software decode these positions
  localparam int FLG_TX_UNDER = 0;
  localparam int FLG_RX_OVER  = 1;
  localparam int FLG_TX_LOW   = 2;
  localparam int FLG_RX_HIGH  = 3;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } fifo_dir_e;

endpackage

// File: rtl/afd_req_gen.sv
module afd_req_gen
  import audio_fifo_dreq_pkg::*;
#(
  parameter int        DEPTH = 8,
  parameter int        BURST = 4,
  parameter int        CNT_W = 4,
  parameter fifo_dir_e DIR   = DIR_TX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic             burst,
  input  logic             dma_en,
  input  logic             dbg_hold,
  input  logic             dbg_active,
  input  logic             flush,
  output logic             dreq
);

  localparam logic [CNT_W-1:0] DEPTH_C    = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TX_BURST_C = CNT_W'(DEPTH - BURST);
  localparam logic [CNT_W-1:0] RX_BURST_C = CNT_W'(BURST);

  logic want_single;
  logic want_burst;
  logic dreq_d;
  logic dreq_q;

  generate
    if (DIR == DIR_RX) begin : g_rx
      // receive side drains: ask when words are waiting
      assign want_single = (level != '0);
      assign want_burst  = (level >= RX_BURST_C);
    end else begin : g_tx
      // transmit side fills: ask when room is available
      assign want_single = (level < DEPTH_C);
      assign want_burst  = (level <= TX_BURST_C);
    end
  endgenerate

  always_comb begin
    dreq_d = 1'b0;
    if (dma_en && !(dbg_hold && dbg_active) && !flush) begin
      dreq_d = burst ? want_burst : want_single;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
    end else begin
      dreq_q <= dreq_d;
    end
  end

  assign dreq = dreq_q;

endmodule

// File: rtl/afd_flag_unit.sv
module afd_flag_unit
  import audio_fifo_dreq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_wmark,
  input  logic [CNT_W-1:0] rx_wmark,
  input  logic             tx_underrun,
  input  logic             rx_overrun,
  input  logic [1:0]       err_clr,
  input  logic             tx_flush,
  input  logic             rx_flush,
  output flag_vec_t        flags
);

  logic [1:0] evt;
  logic [1:0] clr;
  logic [1:0] sticky_en;
  logic [1:0] sticky_d;
  logic [1:0] sticky_q;
  logic       low_d;
  logic       high_d;
  logic       low_q;
  logic       high_q;

  assign evt = {rx_overrun, tx_underrun};
  assign clr = err_clr | {rx_flush, tx_flush};

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_sticky
      // an event in the clear cycle wins so it is never lost
      assign sticky_en[gi] = evt[gi] | clr[gi];
      assign sticky_d[gi]  = evt[gi];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sticky_q[gi] <= 1'b0;
        end else if (sticky_en[gi]) begin
          sticky_q[gi] <= sticky_d[gi];
        end
      end
    end
  endgenerate

  always_comb begin
    low_d  = (tx_level <= tx_wmark);
    high_d = (rx_level >= rx_wmark);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 1'b0;
      high_q <= 1'b0;
    end else begin
      low_q  <= low_d;
      high_q <= high_d;
    end
  end

  always_comb begin
    flags               = '0;
    flags[FLG_TX_UNDER] = sticky_q[0];
    flags[FLG_RX_OVER]  = sticky_q[1];
    flags[FLG_TX_LOW]   = low_q;
    flags[FLG_RX_HIGH]  = high_q;
  end

endmodule

// File: rtl/afd_irq_merge.sv
module afd_irq_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq
);

  assign irq = |(flags & enables);

endmodule

// File: rtl/audio_fifo_dreq.sv
module audio_fifo_dreq
  import audio_fifo_dreq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_wmark,
  input  logic [CNT_W-1:0] rx_wmark,
  input  logic             tx_burst,
  input  logic             rx_burst,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic             tx_dbg_hold,
  input  logic             rx_dbg_hold,
  input  logic             dbg_active,
  input  logic             tx_underrun,
  input  logic             rx_overrun,
  input  logic             tx_flush,
  input  logic             rx_flush,
  input  logic [1:0]       err_clr,
  input  logic [3:0]       irq_en,
  output logic             tx_dreq,
  output logic             rx_dreq,
  output logic [3:0]       flags,
  output logic             irq
);

  flag_vec_t flag_w;

  afd_req_gen #(
    .DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W), .DIR(DIR_TX)
  ) u_tx_req (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .burst(tx_burst),
    .dma_en(tx_dma_en), .dbg_hold(tx_dbg_hold), .dbg_active(dbg_active),
    .flush(tx_flush), .dreq(tx_dreq)
  );

  afd_req_gen #(
    .DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W), .DIR(DIR_RX)
  ) u_rx_req (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .burst(rx_burst),
    .dma_en(rx_dma_en), .dbg_hold(rx_dbg_hold), .dbg_active(dbg_active),
    .flush(rx_flush), .dreq(rx_dreq)
  );

  afd_flag_unit #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_wmark(tx_wmark), .rx_wmark(rx_wmark),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
    .err_clr(err_clr), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .flags(flag_w)
  );

  afd_irq_merge #(.N(NUM_FLAGS)) u_irq (
    .flags(flag_w), .enables(irq_en), .irq(irq)
  );

  assign flags = flag_w;

endmodule

// File: rtl/audio_fifo_dreq_chk.sv
module audio_fifo_dreq_chk #(
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_level,
  input logic [CNT_W-1:0] rx_level,
  input logic [CNT_W-1:0] tx_wmark,
  input logic [CNT_W-1:0] rx_wmark,
  input logic             tx_burst,
  input logic             rx_burst,
  input logic             tx_dma_en,
  input logic             rx_dma_en,
  input logic             tx_dbg_hold,
  input logic             rx_dbg_hold,
  input logic             dbg_active,
  input logic             tx_underrun,
  input logic             rx_overrun,
  input logic             tx_flush,
  input logic             rx_flush,
  input logic [1:0]       err_clr,
  input logic [3:0]       irq_en,
  input logic             tx_dreq,
  input logic             rx_dreq,
  input logic [3:0]       flags,
  input logic             irq
);

  logic tx_go;
  logic rx_go;
  assign tx_go = tx_dma_en && !(tx_dbg_hold && dbg_active) && !tx_flush;
  assign rx_go = rx_dma_en && !(rx_dbg_hold && dbg_active) && !rx_flush;

  a_r2_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && !tx_burst) |=> (tx_dreq == ($past(tx_level) < CNT_W'(DEPTH))));

  a_r3_tx_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && tx_burst) |=> (tx_dreq == ($past(tx_level) <= CNT_W'(DEPTH - BURST))));

  a_r4_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_go && !rx_burst) |=> (rx_dreq == ($past(rx_level) != '0)));

  a_r5_rx_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_go && rx_burst) |=> (rx_dreq == ($past(rx_level) >= CNT_W'(BURST))));

  a_r6_tx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_en |=> !tx_dreq);

  a_r6_rx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_en |=> !rx_dreq);

  a_r7_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && tx_dbg_hold) |=> !tx_dreq);

  a_r8_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !tx_underrun) |=> (!tx_dreq && !flags[0]));

  a_r8_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !rx_overrun) |=> (!rx_dreq && !flags[1]));

  a_r9_low_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= tx_wmark) |=> flags[2]);

  a_r9_low_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level > tx_wmark) |=> !flags[2]);

  a_r10_high_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= rx_wmark) |=> flags[3]);

  a_r10_high_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < rx_wmark) |=> !flags[3]);

  a_r11_under_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> flags[0]);

  a_r11_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_underrun && !err_clr[0] && !tx_flush) |=> $stable(flags[0]));

  a_r11_over_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_overrun && !err_clr[1] && !rx_flush) |=> $stable(flags[1]));

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!tx_dreq && !rx_dreq && flags == '0 && !irq);
    end
  end

  always_comb begin
    if (rst_n) begin
      a_r12_irq_gate: assert (irq == ((flags[0] && irq_en[0]) || (flags[1] && irq_en[1]) ||
                                      (flags[2] && irq_en[2]) || (flags[3] && irq_en[3])));
    end
  end

endmodule

bind audio_fifo_dreq audio_fifo_dreq_chk #(
  .DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
  .tx_wmark(tx_wmark), .rx_wmark(rx_wmark), .tx_burst(tx_burst),
  .rx_burst(rx_burst), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
  .tx_dbg_hold(tx_dbg_hold), .rx_dbg_hold(rx_dbg_hold),
  .dbg_active(dbg_active), .tx_underrun(tx_underrun),
  .rx_overrun(rx_overrun), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .err_clr(err_clr), .irq_en(irq_en), .tx_dreq(tx_dreq),
  .rx_dreq(rx_dreq), .flags(flags), .irq(irq)
);

// File: tb/audio_fifo_dreq_tb.sv
module audio_fifo_dreq_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] tx_level, rx_level, tx_wmark, rx_wmark;
  logic       tx_burst, rx_burst, tx_dma_en, rx_dma_en;
  logic       tx_dbg_hold, rx_dbg_hold, dbg_active;
  logic       tx_underrun, rx_overrun, tx_flush, rx_flush;
  logic [1:0] err_clr;
  logic [3:0] irq_en;
  logic       tx_dreq, rx_dreq, irq;
  logic [3:0] flags;

  int checks;
  int errors;
  bit done;

  audio_fifo_dreq u_dut (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_wmark(tx_wmark), .rx_wmark(rx_wmark), .tx_burst(tx_burst),
    .rx_burst(rx_burst), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_dbg_hold(tx_dbg_hold), .rx_dbg_hold(rx_dbg_hold),
    .dbg_active(dbg_active), .tx_underrun(tx_underrun),
    .rx_overrun(rx_overrun), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .err_clr(err_clr), .irq_en(irq_en), .tx_dreq(tx_dreq),
    .rx_dreq(rx_dreq), .flags(flags), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {tx_level, rx_level, tx_burst, rx_burst, tx_en, rx_en, exp_tx, exp_rx}
  localparam int NVEC = 9;
  localparam logic [13:0] VEC [NVEC] = '{
    {4'd0,  4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd7,  4'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'd8,  4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd4,  4'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd5,  4'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd0,  4'd8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'd3,  4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd8,  4'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd15, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0;
    tx_level = 0; rx_level = 0; tx_wmark = 0; rx_wmark = 0;
    tx_burst = 0; rx_burst = 0; tx_dma_en = 0; rx_dma_en = 0;
    tx_dbg_hold = 0; rx_dbg_hold = 0; dbg_active = 0;
    tx_underrun = 0; rx_overrun = 0; tx_flush = 0; rx_flush = 0;
    err_clr = 0; irq_en = 4'hF;
    tx_underrun = 1;
    repeat (3) @(negedge clk);
    // R1: reset holds everything low even with an event and all irq enables set
    chk("R1 reset", {tx_dreq, rx_dreq, irq, 1'b0}, 4'h0);
    chk("R1 reset flags", flags, 4'h0);
    tx_underrun = 0; irq_en = 0;
    rst_n = 1;
    step();

    // request thresholds
    for (int i = 0; i < NVEC; i++) begin
      {tx_level, rx_level, tx_burst, rx_burst, tx_dma_en, rx_dma_en} = VEC[i][13:2];
      step();
      chk(!VEC[i][3] ? "R6 tx disabled" : (tx_burst ? "R3 tx burst" : "R2 tx single"),
          {3'b0, tx_dreq}, {3'b0, VEC[i][1]});
      chk(!VEC[i][2] ? "R6 rx disabled" : (rx_burst ? "R5 rx burst" : "R4 rx single"),
          {3'b0, rx_dreq}, {3'b0, VEC[i][0]});
    end

    // R7 debug hold-off, per direction
    tx_level = 2; rx_level = 2; tx_burst = 0; rx_burst = 0;
    tx_dma_en = 1; rx_dma_en = 1; dbg_active = 1; tx_dbg_hold = 1;
    step();
    chk("R7 tx held", {3'b0, tx_dreq}, 4'h0);
    chk("R7 rx unaffected", {3'b0, rx_dreq}, 4'h1);
    rx_dbg_hold = 1; tx_dbg_hold = 0;
    step();
    chk("R7 rx held", {3'b0, rx_dreq}, 4'h0);
    chk("R7 tx resumes", {3'b0, tx_dreq}, 4'h1);
    dbg_active = 0; rx_dbg_hold = 0;

    // R9 / R10 level flags at the boundaries
    tx_wmark = 3; rx_wmark = 5; tx_level = 3; rx_level = 5;
    step();
    chk("R9 low at mark", {3'b0, flags[2]}, 4'h1);
    chk("R10 high at mark", {3'b0, flags[3]}, 4'h1);
    tx_level = 4; rx_level = 4;
    step();
    chk("R9 low above mark", {3'b0, flags[2]}, 4'h0);
    chk("R10 high below mark", {3'b0, flags[3]}, 4'h0);

    // R11 sticky underrun
    tx_underrun = 1;
    step();
    tx_underrun = 0;
    chk("R11 underrun set", {3'b0, flags[0]}, 4'h1);
    repeat (5) step();
    chk("R11 underrun holds", {3'b0, flags[0]}, 4'h1);
    err_clr = 2'b01; tx_underrun = 1;
    step();
    err_clr = 0; tx_underrun = 0;
    chk("R11 event beats clear", {3'b0, flags[0]}, 4'h1);
    err_clr = 2'b01;
    step();
    err_clr = 0;
    chk("R11 underrun cleared", {3'b0, flags[0]}, 4'h0);
    rx_overrun = 1;
    step();
    rx_overrun = 0;
    chk("R11 overrun set", {3'b0, flags[1]}, 4'h1);

    // R12 interrupt gating, combinational on irq_en
    irq_en = 4'b0001;
    #1 chk("R12 masked", {3'b0, irq}, 4'h0);
    irq_en = 4'b0010;
    #1 chk("R12 overrun enabled", {3'b0, irq}, 4'h1);

    // R8 flush drops rx request one cycle and clears overrun
    rx_flush = 1;
    step();
    rx_flush = 0;
    chk("R8 rx flush drops request", {3'b0, rx_dreq}, 4'h0);
    chk("R8 rx flush clears overrun", {3'b0, flags[1]}, 4'h0);
    chk("R12 irq follows cleared flag", {3'b0, irq}, 4'h0);
    step();
    chk("R8 rx request returns", {3'b0, rx_dreq}, 4'h1);
    tx_underrun = 1;
    step();
    tx_underrun = 0;
    tx_flush = 1;
    step();
    tx_flush = 0;
    chk("R8 tx flush", {2'b0, tx_dreq, flags[0]}, 4'h0);
    step();
    chk("R8 tx request returns", {3'b0, tx_dreq}, 4'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule